// File: doc/BRIEF.md
# Halving-Tree Lane Sum Sequencer

This block holds one partial-sum register for each of a fixed number of lanes. It folds those registers into a single total that ends up in lane 0. On each clock step, the lower lanes take in the sums of lanes a fixed distance above them. The distance is roughly half of the lanes still active, so the active count shrinks each step until one lane remains. Every step completes in one clock edge for all lanes at once, so the clock edge acts as the barrier between steps.

A wide load port writes every lane in one cycle. A start pulse then begins a reduction. The start pulse also samples a mode input that picks one of two halving rules:

- The floor rule halves the count rounding down, and gives the odd lane left over to lane 0.
- The ceiling rule halves rounding up, and leaves the middle lane idle when the count is odd.

Both rules give the wrap-around sum of all loaded values. They differ in how many steps they take. When the reduction finishes, a one-cycle done pulse is raised. At that point the total and the step count are on the outputs.

Top module: `tsr_top`

## Requirements
- R1: After reset, `busy`, `done`, `step_cnt` and `total` are all zero.
- R2: While idle, `load_en` writes every lane at once. Lane i takes `load_vec[i*W +: W]`. While busy, `load_en` and `load_vec` have no effect on the result.
- R3: A `start` pulse while idle raises `busy` on the next cycle and latches `mode_ceil` (0 = floor rule, 1 = ceiling rule). While busy, changes to `mode_ceil` and further `start` pulses are ignored, and no extra reduction or done pulse is produced.
- R4: Floor rule, from count c: h = floor(c/2). Each lane i < h adds lane i+h into itself. When c is odd, lane 0 also adds lane c-1 in the same step. The next count is h. With 13 lanes this takes 3 steps, and with 100 lanes it takes 6.
- R5: Ceiling rule, from count c: h = ceil(c/2). Each lane i < floor(c/2) adds lane i+h into itself. When c is odd, lane h-1 neither sends nor receives. The next count is h. With 13 lanes this takes 4 steps, and with 100 lanes it takes 7.
- R6: When done, `total` equals the sum of all loaded lane values modulo 2^W, in either mode.
- R7: One step is taken per clock. `busy` stays high for exactly as many cycles as there are steps, and `step_cnt` rises by one on each of those cycles.
- R8: `done` is high for exactly one cycle, in the same cycle that `busy` falls. `total` and `step_cnt` are valid in that cycle and hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write all lanes from `load_vec` (ignored while busy) |
| load_vec | input | LANES*W | Lane values, lane i in bits [i*W +: W] |
| start | input | 1 | Begin a reduction (ignored while busy) |
| mode_ceil | input | 1 | Halving rule sampled at start: 0 floor, 1 ceiling |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse at completion |
| step_cnt | output | $clog2(LANES+1)+1 | Steps taken by the current or last reduction |
| total | output | W | Lane 0 sum, final when `done` is high |

## Verification
The bench builds the block with 13 lanes of 8 bits.

- The odd lane count makes the floor rule's lane-0 fix-up fire on the first step, and leaves a middle lane idle under the ceiling rule.
- The two rules differ in step count (3 against 4), so a wrongly latched mode is visible at the ports.
- Eight-bit lanes make wrap-around reachable with all-ones loads.
- One-hot loads on the last lane and on the middle lane check the field positions and the skipped-lane paths.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    typedef enum logic {
        SCHED_FLOOR = 1'b0,
        SCHED_CEIL  = 1'b1
    } sched_e;
endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
    import tsr_pkg::*;
#(
    parameter int LANES = 100,
    parameter int CW    = 7,
    parameter int SW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_ceil,
    output logic          busy,
    output logic          done,
    output logic          step_en,
    output logic          odd_fix,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] half,
    output logic [CW-1:0] rx_lim,
    output logic [SW-1:0] step_cnt
);
    typedef struct packed {
        logic          busy;
        logic          done;
        sched_e        mode;
        logic [CW-1:0] cnt;
        logic [SW-1:0] step;
    } ctrl_t;

    ctrl_t s_q, s_d;

    // schedule decode for the current count
    always_comb begin
        if (s_q.mode == SCHED_CEIL) begin
            half    = (s_q.cnt >> 1) + CW'(s_q.cnt[0]);
            rx_lim  = s_q.cnt >> 1;
            odd_fix = 1'b0;
        end else begin
            half    = s_q.cnt >> 1;
            rx_lim  = s_q.cnt >> 1;
            odd_fix = s_q.cnt[0];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.cnt  = half;
            s_d.step = s_q.step + 1'b1;
            if (half <= CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (start) begin
            s_d.mode = mode_ceil ? SCHED_CEIL : SCHED_FLOOR;
            s_d.cnt  = CW'(LANES);
            s_d.step = '0;
            if (LANES > 1) s_d.busy = 1'b1;
            else           s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign step_en  = s_q.busy;
    assign cnt      = s_q.cnt;
    assign step_cnt = s_q.step;

    // R7
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (s_q.step == SW'($past(s_q.step) + 1'b1)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy);

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable(s_q.mode));

    // R4 R5
    count_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (s_q.cnt < $past(s_q.cnt)));
endmodule

// File: rtl/tsr_lanes.sv
module tsr_lanes #(
    parameter int LANES = 100,
    parameter int W     = 32,
    parameter int CW    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [LANES*W-1:0] load_vec,
    input  logic               step_en,
    input  logic               odd_fix,
    input  logic [CW-1:0]      cnt,
    input  logic [CW-1:0]      half,
    input  logic [CW-1:0]      rx_lim,
    output logic [W-1:0]       total
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0][W-1:0] lane_q, lane_d;
    logic [W-1:0]            tail;

    always_comb begin
        tail = '0;
        if (odd_fix && cnt != '0) tail = lane_q[LW'(cnt - 1'b1)];
    end

    always_comb begin
        lane_d = lane_q;
        for (int g = 0; g < LANES; g++) begin
            logic [CW:0]  idx;
            logic [W-1:0] partner;
            idx     = (CW+1)'(g) + {1'b0, half};
            partner = '0;
            if (idx < (CW+1)'(LANES)) partner = lane_q[LW'(idx)];
            if (load_en) begin
                lane_d[g] = load_vec[g*W +: W];
            end else if (step_en && (CW'(g) < rx_lim)) begin
                lane_d[g] = lane_q[g] + partner;
                if (g == 0) lane_d[g] = lane_q[g] + partner + tail;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign total = lane_q[0];
endmodule

// File: rtl/tsr_top.sv
module tsr_top #(
    parameter int LANES = 100,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [LANES*W-1:0]         load_vec,
    input  logic                       start,
    input  logic                       mode_ceil,
    output logic                       busy,
    output logic                       done,
    output logic [$clog2(LANES+1):0]   step_cnt,
    output logic [W-1:0]               total
);
    localparam int CW = $clog2(LANES + 1);
    localparam int SW = CW + 1;

    logic          step_en, odd_fix;
    logic [CW-1:0] cnt, half, rx_lim;

    tsr_ctrl #(.LANES(LANES), .CW(CW), .SW(SW)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_ceil(mode_ceil),
        .busy     (busy),
        .done     (done),
        .step_en  (step_en),
        .odd_fix  (odd_fix),
        .cnt      (cnt),
        .half     (half),
        .rx_lim   (rx_lim),
        .step_cnt (step_cnt)
    );

    tsr_lanes #(.LANES(LANES), .W(W), .CW(CW)) i_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en && !busy),
        .load_vec(load_vec),
        .step_en (step_en),
        .odd_fix (odd_fix),
        .cnt     (cnt),
        .half    (half),
        .rx_lim  (rx_lim),
        .total   (total)
    );
endmodule

// File: tb/test_tsr_top.sv
module test_tsr_top;
    localparam int LANES = 13;
    localparam int W     = 8;
    localparam int SW    = $clog2(LANES + 1) + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load_en = 1'b0;
    logic               start = 1'b0;
    logic               mode_ceil = 1'b0;
    logic [LANES*W-1:0] load_vec = '0;
    logic               busy, done;
    logic [SW-1:0]      step_cnt;
    logic [W-1:0]       total;

    always #2 clk = ~clk;

    tsr_top #(.LANES(LANES), .W(W)) i_tsr_top (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_vec(load_vec),
        .start(start), .mode_ceil(mode_ceil), .busy(busy), .done(done),
        .step_cnt(step_cnt), .total(total)
    );

    typedef struct {
        logic [W-1:0] sum;
        int           steps;
        string        sum_req;
        string        step_req;
    } exp_t;

    exp_t sb[$];
    int checks = 0, fails = 0, done_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sched_steps(input int n, input bit ceil_rule);
        int c = n, s = 0;
        while (c > 1) begin
            c = ceil_rule ? (c + 1) / 2 : c / 2;
            s++;
        end
        return s;
    endfunction

    // monitor: pops expectations on each done pulse
    int           busy_run = 0;
    bit           prev_done = 0;
    logic [W-1:0] last_sum = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                chk(!done, "R8", "done longer than one cycle", int'(done), 0);
                chk(total == last_sum, "R8", "total not held", int'(total), int'(last_sum));
            end
            if (done) begin
                exp_t e;
                done_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R3", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(total == e.sum, e.sum_req, "total", int'(total), int'(e.sum));
                    chk(int'(step_cnt) == e.steps, e.step_req, "step count", int'(step_cnt), e.steps);
                    chk(busy_run == e.steps, "R7", "busy cycles", busy_run, e.steps);
                    chk(!busy, "R8", "busy at done", int'(busy), 0);
                    last_sum = e.sum;
                end
                busy_run = 0;
            end
            if (busy) busy_run++;
            prev_done = done;
        end
    end

    // driver: loads lanes, starts, pushes the expectation
    task automatic run(input logic [W-1:0] v [LANES], input bit ceil_rule, input bit disturb);
        exp_t e;
        logic [W-1:0] acc = '0;
        for (int i = 0; i < LANES; i++) acc = acc + v[i];
        e.sum      = acc;
        e.steps    = sched_steps(LANES, ceil_rule);
        e.sum_req  = disturb ? "R2" : "R6";
        e.step_req = disturb ? "R3" : (ceil_rule ? "R5" : "R4");
        @(negedge clk);
        load_en = 1'b1;
        for (int i = 0; i < LANES; i++) load_vec[i*W +: W] = v[i];
        @(negedge clk);
        load_en   = 1'b0;
        start     = 1'b1;
        mode_ceil = ceil_rule;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after start", int'(busy), 1);
        if (disturb) begin
            // R2 R3: mode flip, restart and reload while busy must do nothing
            mode_ceil = !ceil_rule;
            start     = 1'b1;
            load_en   = 1'b1;
            load_vec  = ~load_vec;
            @(negedge clk);
            start     = 1'b0;
            load_en   = 1'b0;
            mode_ceil = ceil_rule;
        end
        wait (sb.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v [LANES];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(step_cnt == '0, "R1", "step_cnt after reset", int'(step_cnt), 0);
        chk(total == '0, "R1", "total after reset", int'(total), 0);

        for (int i = 0; i < LANES; i++) v[i] = W'(i + 1);
        run(v, 1'b0, 1'b0);
        run(v, 1'b1, 1'b0);

        for (int i = 0; i < LANES; i++) v[i] = '1;   // R6 wraparound
        run(v, 1'b0, 1'b0);
        run(v, 1'b1, 1'b0);

        for (int i = 0; i < LANES; i++) v[i] = W'(i * 37 + 11);
        run(v, 1'b0, 1'b1);
        run(v, 1'b1, 1'b1);

        for (int i = 0; i < LANES; i++) v[i] = '0;   // R4 odd fix-up from last lane
        v[LANES-1] = 8'd5;
        run(v, 1'b0, 1'b0);

        for (int i = 0; i < LANES; i++) v[i] = '0;   // R5 idle middle lane
        v[6] = 8'd9;
        run(v, 1'b1, 1'b0);

        chk(done_seen == 8, "R3", "done pulse count", done_seen, 8);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule